// File: doc/BRIEF.md
# Line-Counted Multi-Slope Shutter Sequencer

This block times one exposure of an image array in whole line periods. A line tick arrives once per line, from whatever produces the line rhythm. A frame-start strobe opens a new exposure. The block then drives four outputs:

- a pixel reset level, which is high from the start of the exposure;
- an optional dual-slope reset pulse;
- an optional triple-slope reset pulse;
- a frame-transfer pulse, which ends integration.

Every event is placed by a 12-bit register that holds the wanted line index plus one.

A single line counter serves all the events. The counter clears on frame start and advances once per line tick. Each event compares its own target line against the counter. The four registers and the two enable bits are captured when frame start arrives, so software may rewrite them while an exposure is in progress without disturbing it. A reset length below the minimum is raised to the minimum.

Top module: `shutter_seq`

## Requirements
- R1: After reset, and until the first frame start, all four outputs are 0 whatever the line ticks do.
- R2: The four 12-bit registers and both enable bits are captured in the cycle of frame start. Changes made to them later in the same frame leave every output unchanged.
- R3: With captured reset length L (where L >= 2), pix_reset is high from the cycle after frame start. It stays high while fewer than L-1 line ticks have been counted since that frame start, and it falls with the tick that makes the count L-1.
- R4: A reset length of 0 or 1 behaves exactly like 2, so pix_reset stays high for one line period.
- R5: With dual_en captured as 1 and dual position P, dual_pulse is high exactly while the tick count equals P-1. That is one line period. A P of 0 is treated as 1, which gives line 0.
- R6: With dual_en captured as 0, dual_pulse stays 0 for the whole frame, whatever dual_pos holds.
- R7: triple_pulse follows the rules of R5 and R6, using triple_en and triple_pos.
- R8: xfer_pulse is always enabled. It is high exactly while the tick count equals xfer_pos-1, with 0 treated as 1.
- R9: Once 4096 ticks have been counted in a frame, the counter no longer wraps. Every output then stays 0 until the next frame start, so an event at line 0 never fires a second time.
- R10: When frame start and line tick arrive in the same cycle, frame start wins and the count restarts at 0. A frame start in the middle of a frame restarts the exposure with the newly captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe that opens an exposure and captures the registers |
| line_tick | input | 1 | One-cycle strobe, once per line period |
| reset_len | input | 12 | Reset length, in lines plus one (minimum 2) |
| dual_pos | input | 12 | Dual-slope reset line, plus one |
| triple_pos | input | 12 | Triple-slope reset line, plus one |
| xfer_pos | input | 12 | Frame-transfer line, plus one |
| dual_en | input | 1 | Enables the dual-slope pulse |
| triple_en | input | 1 | Enables the triple-slope pulse |
| pix_reset | output | 1 | Pixel reset level |
| dual_pulse | output | 1 | Dual-slope reset, one line period long |
| triple_pulse | output | 1 | Triple-slope reset, one line period long |
| xfer_pulse | output | 1 | Frame transfer, one line period long |

## Verification
The hardest case to reach is counter exhaustion. The counter only runs out after 4096 ticks in one frame, and only an event placed at line 0 shows whether the count wrapped. The stimulus sets the dual-slope position to 1 and then issues over four thousand back-to-back line ticks without a frame start. The cycle-by-cycle model confirms that the pulse never returns and that the transfer fires once, at line 4094.

A second corner is a frame start that coincides with a tick, or that arrives mid-exposure after the registers were rewritten. The stimulus drives both of these directly.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

    localparam int LINE_W = 12;
    localparam int N_EV   = 3;

    typedef logic [LINE_W-1:0] line_t;

    localparam line_t MIN_RST_LEN = line_t'(2);

    typedef enum logic [1:0] {
        EV_DUAL   = 2'd0,
        EV_TRIPLE = 2'd1,
        EV_XFER   = 2'd2
    } ev_kind_e;

    typedef struct packed {
        line_t                  rst_lines;
        line_t [N_EV-1:0]       ev_line;
        logic  [N_EV-1:0]       ev_en;
    } sched_t;

    function automatic line_t reg_to_line(line_t v);
        return (v == '0) ? '0 : (v - line_t'(1));
    endfunction

    function automatic line_t reset_span(line_t v);
        return (v < MIN_RST_LEN) ? (MIN_RST_LEN - line_t'(1)) : (v - line_t'(1));
    endfunction

endpackage

// File: rtl/shutter_cfg_latch.sv
module shutter_cfg_latch
    import shutter_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_start,
    input  line_t  reset_len,
    input  line_t  dual_pos,
    input  line_t  triple_pos,
    input  line_t  xfer_pos,
    input  logic   dual_en,
    input  logic   triple_en,
    output sched_t sched
);

    sched_t sched_next;

    always_comb begin
        sched_next.rst_lines                = reset_span(reset_len);
        sched_next.ev_line[int'(EV_DUAL)]   = reg_to_line(dual_pos);
        sched_next.ev_line[int'(EV_TRIPLE)] = reg_to_line(triple_pos);
        sched_next.ev_line[int'(EV_XFER)]   = reg_to_line(xfer_pos);
        sched_next.ev_en[int'(EV_DUAL)]     = dual_en;
        sched_next.ev_en[int'(EV_TRIPLE)]   = triple_en;
        sched_next.ev_en[int'(EV_XFER)]     = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sched <= '0;
        end else if (frame_start) begin
            sched <= sched_next;
        end
    end

endmodule

// File: rtl/shutter_line_counter.sv
module shutter_line_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_start,
    input  logic         line_tick,
    output logic         live,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic active;
    logic spent;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            spent  <= 1'b0;
            count  <= '0;
        end else if (frame_start) begin
            active <= 1'b1;
            spent  <= 1'b0;
            count  <= '0;
        end else if (line_tick && active && !spent) begin
            if (count == CNT_MAX) begin
                spent <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    assign live = active && !spent;

endmodule

// File: rtl/shutter_event_match.sv
module shutter_event_match #(
    parameter int W = 12
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] target,
    input  logic         enable,
    input  logic         live,
    output logic         hit
);

    always_comb begin
        hit = live && enable && (count == target);
    end

endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
    import shutter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_tick,
    input  logic [LINE_W-1:0] reset_len,
    input  logic [LINE_W-1:0] dual_pos,
    input  logic [LINE_W-1:0] triple_pos,
    input  logic [LINE_W-1:0] xfer_pos,
    input  logic              dual_en,
    input  logic              triple_en,
    output logic              pix_reset,
    output logic              dual_pulse,
    output logic              triple_pulse,
    output logic              xfer_pulse
);

    sched_t          sched;
    line_t           count;
    logic            live;
    logic [N_EV-1:0] hits;

    shutter_cfg_latch u_cfg (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .reset_len   (reset_len),
        .dual_pos    (dual_pos),
        .triple_pos  (triple_pos),
        .xfer_pos    (xfer_pos),
        .dual_en     (dual_en),
        .triple_en   (triple_en),
        .sched       (sched)
    );

    shutter_line_counter #(.W(LINE_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .line_tick   (line_tick),
        .live        (live),
        .count       (count)
    );

    for (genvar k = 0; k < N_EV; k++) begin : g_ev
        shutter_event_match #(.W(LINE_W)) u_match (
            .count  (count),
            .target (sched.ev_line[k]),
            .enable (sched.ev_en[k]),
            .live   (live),
            .hit    (hits[k])
        );
    end

    always_comb begin
        pix_reset    = live && (count < sched.rst_lines);
        dual_pulse   = hits[int'(EV_DUAL)];
        triple_pulse = hits[int'(EV_TRIPLE)];
        xfer_pulse   = hits[int'(EV_XFER)];
    end

endmodule

// File: rtl/shutter_seq_chk.sv
module shutter_seq_chk (
    input logic clk,
    input logic rst,
    input logic frame_start,
    input logic line_tick,
    input logic dual_en,
    input logic pix_reset,
    input logic dual_pulse,
    input logic triple_pulse,
    input logic xfer_pulse
);

    logic seen_frame;

    always_ff @(posedge clk) begin
        if (rst) seen_frame <= 1'b0;
        else if (frame_start) seen_frame <= 1'b1;
    end

    // R1
    a_r1_idle_before_frame: assert property (@(posedge clk) disable iff (rst)
        !seen_frame |-> !(pix_reset || dual_pulse || triple_pulse || xfer_pulse));

    // R3 / R4: the reset level is high in the cycle after every frame start
    a_r3_reset_opens: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> pix_reset);

    // R3: the reset level rises only after a frame start
    a_r3_reset_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_reset) |-> $past(frame_start));

    // R5: the dual pulse holds across a line
    a_r5_dual_holds: assert property (@(posedge clk) disable iff (rst)
        (dual_pulse && !line_tick && !frame_start) |=> dual_pulse);

    // R5: the dual pulse lasts one line only
    a_r5_dual_one_line: assert property (@(posedge clk) disable iff (rst)
        (dual_pulse && line_tick && !frame_start) |=> !dual_pulse);

    // R6
    a_r6_dual_gated: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !dual_en) |=> !dual_pulse);

    // R7
    a_r7_triple_one_line: assert property (@(posedge clk) disable iff (rst)
        (triple_pulse && line_tick && !frame_start) |=> !triple_pulse);

    // R8
    a_r8_xfer_one_line: assert property (@(posedge clk) disable iff (rst)
        (xfer_pulse && line_tick && !frame_start) |=> !xfer_pulse);

    // R10
    a_r10_start_wins: assert property (@(posedge clk) disable iff (rst)
        (frame_start && line_tick) |=> pix_reset);

endmodule

bind shutter_seq shutter_seq_chk u_chk (.*);

// File: tb/sim_shutter_seq.sv
`timescale 1ns/1ps
module sim_shutter_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        line_tick = 1'b0;
    logic [11:0] reset_len = 12'd2;
    logic [11:0] dual_pos = 12'd0;
    logic [11:0] triple_pos = 12'd0;
    logic [11:0] xfer_pos = 12'd0;
    logic        dual_en = 1'b0;
    logic        triple_en = 1'b0;
    logic        pix_reset, dual_pulse, triple_pulse, xfer_pulse;

    always #5 clk = ~clk;

    shutter_seq u0 (.*);

    // behavioural reference
    bit    m_act;
    int    m_n;
    int    m_len, m_dual, m_triple, m_xfer;
    bit    m_de, m_te;
    int    n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    function automatic int line_of(int v);
        return (v == 0) ? 0 : v - 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 1'b0; m_n = 0;
        end else if (frame_start) begin
            m_act = 1'b1; m_n = 0;
            m_len = (reset_len < 2) ? 2 : int'(reset_len);
            m_dual = line_of(int'(dual_pos));
            m_triple = line_of(int'(triple_pos));
            m_xfer = line_of(int'(xfer_pos));
            m_de = dual_en; m_te = triple_en;
        end else if (line_tick && m_act) begin
            m_n = m_n + 1;
        end
    end

    task automatic cmp1(string nm, logic got, logic exp);
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: got %0b expected %0b", cur_req, nm, cyc, got, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            n_cmp++;
            cmp1("pix_reset", pix_reset, m_act && (m_n < m_len - 1));
            cmp1("dual_pulse", dual_pulse, m_act && m_de && (m_n == m_dual));
            cmp1("triple_pulse", triple_pulse, m_act && m_te && (m_n == m_triple));
            cmp1("xfer_pulse", xfer_pulse, m_act && (m_n == m_xfer));
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog expired");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    task automatic step(bit fs, bit tk);
        @(negedge clk);
        #1;
        frame_start = fs;
        line_tick = tk;
        @(posedge clk);
        #1;
        frame_start = 1'b0;
        line_tick = 1'b0;
    endtask

    task automatic ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            for (int g = 0; g < (gap == 0 ? 0 : i % (gap + 1)); g++) step(0, 0);
            step(0, 1);
        end
    endtask

    task automatic setcfg(int rl, int d, int t, int x, bit de, bit te);
        reset_len = 12'(rl); dual_pos = 12'(d); triple_pos = 12'(t);
        xfer_pos = 12'(x); dual_en = de; triple_en = te;
    endtask

    initial begin
        // R1: reset state, then ticks with no frame start
        cur_req = "R1";
        repeat (3) step(0, 0);
        rst = 1'b0;
        ticks(5, 1);

        // R3: normal exposure with irregular tick spacing
        cur_req = "R3";
        setcfg(6, 3, 8, 10, 1, 1);
        step(1, 0);
        ticks(14, 2);

        // R4: lengths below the minimum
        cur_req = "R4";
        setcfg(0, 0, 0, 5, 0, 0);
        step(1, 0); ticks(4, 1);
        setcfg(1, 0, 0, 5, 0, 0);
        step(1, 0); ticks(4, 0);

        // R5: dual pulse, including position 0 and 1
        cur_req = "R5";
        setcfg(3, 0, 0, 4, 1, 0);
        step(1, 0); ticks(5, 1);
        setcfg(3, 1, 0, 4, 1, 0);
        step(1, 0); ticks(3, 0);
        setcfg(3, 4, 0, 6, 1, 0);
        step(1, 0); ticks(7, 2);

        // R6: dual disabled, position ignored
        cur_req = "R6";
        setcfg(4, 2, 3, 5, 0, 0);
        step(1, 0); ticks(6, 1);

        // R7: triple pulse with and without enable
        cur_req = "R7";
        setcfg(2, 2, 5, 9, 0, 1);
        step(1, 0); ticks(10, 1);
        setcfg(2, 2, 5, 9, 1, 0);
        step(1, 0); ticks(10, 0);

        // R8: transfer alone, late in the frame
        cur_req = "R8";
        setcfg(2, 0, 0, 12, 0, 0);
        step(1, 0); ticks(14, 2);

        // R2: registers rewritten mid-frame
        cur_req = "R2";
        setcfg(5, 3, 4, 7, 1, 1);
        step(1, 0); ticks(2, 0);
        setcfg(2, 1, 1, 1, 0, 0);
        ticks(8, 1);

        // R10: start with coincident tick; restart mid-frame
        cur_req = "R10";
        setcfg(4, 2, 3, 6, 1, 1);
        step(1, 1); ticks(3, 0);
        setcfg(3, 1, 2, 4, 1, 1);
        step(1, 1); ticks(6, 1);

        // R9: counter exhaustion, no wrap back to line 0
        cur_req = "R9";
        setcfg(2, 1, 0, 4095, 1, 0);
        step(1, 0);
        ticks(4100, 0);
        repeat (4) step(0, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule